// File: doc/BRIEF.md
# Serial Divider Word Loader

The block accepts a three-wire serial stream (serial clock, serial data, load strobe) and turns it into the setting words of a frequency synthesizer's dividers. Each frame is 19 bits long and arrives most significant bit first. Bits are taken on rising edges of the serial clock while the load strobe is low. When the strobe rises, the bit that came in last decides where the frame goes. A 1 sends it to the reference group: a 14-bit reference ratio plus a one-bit prescaler modulus select. A 0 sends it to the counter group: a 7-bit swallow count A and an 11-bit main count B.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the edges are found in the system clock domain. A frame holding a prohibited setting is refused: a reference ratio below 3, a B below 3, or an A larger than B. A refused frame raises an error flag and leaves every latch as it was. The switch-enable output follows the synchronized strobe level. A configured flag rises once both groups have accepted a frame since reset.

The load sequence runs on a three-state machine. ST_SHIFT is the reset state: it shifts bits and moves to ST_CHECK when the strobe rises. ST_CHECK lasts one cycle, commits or refuses the frame, and always moves on to ST_HOLD. ST_HOLD ignores serial clock edges and goes back to ST_SHIFT once the strobe is low again.

Top module: `synth_serial_loader`

## Requirements
- R1: While the load strobe is low, each rising serial clock edge shifts the data bit in at the low end of a 19-bit register, so the first bit sent ends up in bit 18 and the last one in bit 0.
- R2: When bit 0 is 1 at the rising load strobe, the reference ratio takes bits 14..1 and the prescaler select takes bit 15. A and B keep their values.
- R3: When bit 0 is 0 at the rising load strobe, A takes bits 7..1 and B takes bits 18..8. The reference ratio and the prescaler select keep their values.
- R4: The latches change only on a rising load strobe. Shifting in a complete frame with the strobe held low leaves every output as it was.
- R5: The prescaler select output carries the stored bit 15 unchanged: 0 selects the larger modulus pair (128/129) and 1 selects the smaller pair (64/65).
- R6: A reference frame whose ratio is below 3 is refused. Error becomes 1 and no latch changes. A ratio of exactly 3 is accepted.
- R7: A counter frame is refused when B is below 3 or A is greater than B. Error becomes 1 and no latch changes. A equal to B is accepted.
- R8: Switch enable is 1 while the load strobe is held high and 0 while it is low, delayed by at most four system clocks.
- R9: Serial clock edges that arrive while the load strobe is high shift nothing. A second strobe with no new bits reloads the same frame.
- R10: After reset, every latched field, the error flag, switch enable and the configured flag are 0.
- R11: The configured flag rises only after both groups have accepted a frame since reset. A refused frame does not count toward it, and once the flag is 1 it stays 1 until reset.
- R12: The error flag describes the latest load attempt: an accepted frame clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 14 | Latched reference divider ratio |
| pre_sel | output | 1 | Prescaler modulus select (0: 128/129, 1: 64/65) |
| swallow_a | output | 7 | Latched swallow count A |
| count_b | output | 11 | Latched main count B |
| sw_en | output | 1 | Switch enable, follows the load strobe |
| load_err | output | 1 | Latest load attempt was refused |
| configured | output | 1 | Both groups accepted since reset |

## Verification
The hardest case to reach from the ports is a serial clock edge that arrives while the strobe is high. Its only visible effect would come on a later strobe, so the bench holds the strobe up and pulses the clock with data 1. It then drops the strobe and raises it again without sending new bits. If those bits had been shifted in, the control bit would become 1 and the reference ratio would change. A second case is a refused counter frame sent before any valid one. Here the configured flag must stay low even after a valid reference frame.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;
    localparam int FRAME_W = 19;
    localparam int REF_W   = 14;
    localparam int A_W     = 7;
    localparam int B_W     = 11;
    localparam int PRE_POS = REF_W + 1;

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_CHECK = 2'd1,
        ST_HOLD  = 2'd2
    } load_state_t;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             pre;
    } ref_group_t;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } cnt_group_t;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= 1'b0;
                    else        pipe[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= 1'b0;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/sl_frame_check.sv
module sl_frame_check
    import synth_load_pkg::*;
#(
    parameter int MIN_DIV = 3
) (
    input  logic [FRAME_W-1:0] word,
    output logic               to_ref,
    output ref_group_t         ref_f,
    output cnt_group_t         cnt_f,
    output logic               ref_ok,
    output logic               cnt_ok
);
    localparam logic [REF_W-1:0] REF_MIN = REF_W'(MIN_DIV);
    localparam logic [B_W-1:0]   B_MIN   = B_W'(MIN_DIV);

    always_comb begin
        to_ref      = word[0];
        ref_f.ratio = word[REF_W:1];
        ref_f.pre   = word[PRE_POS];
        cnt_f.a     = word[A_W:1];
        cnt_f.b     = word[A_W+B_W:A_W+1];
        ref_ok      = (ref_f.ratio >= REF_MIN);
        cnt_ok      = (cnt_f.b >= B_MIN) && (B_W'(cnt_f.a) <= cnt_f.b);
    end
endmodule

// File: rtl/sl_field_bank.sv
module sl_field_bank
    import synth_load_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_ref,
    input  logic       ld_cnt,
    input  ref_group_t ref_in,
    input  cnt_group_t cnt_in,
    output ref_group_t ref_q,
    output cnt_group_t cnt_q,
    output logic       configured
);
    logic ref_seen;
    logic cnt_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= '0;
            ref_seen <= 1'b0;
        end else if (ld_ref) begin
            ref_q    <= ref_in;
            ref_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cnt_seen <= 1'b0;
        end else if (ld_cnt) begin
            cnt_q    <= cnt_in;
            cnt_seen <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) configured <= 1'b0;
        else        configured <= ref_seen & cnt_seen;
    end

    // R11
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured);

    // R3
    ref_keep_on_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt && !ld_ref) |=> $stable(ref_q));
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import synth_load_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DIV     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_ratio,
    output logic             pre_sel,
    output logic [A_W-1:0]   swallow_a,
    output logic [B_W-1:0]   count_b,
    output logic             sw_en,
    output logic             load_err,
    output logic             configured
);
    logic sclk_s, dat_s, le_s;
    logic sclk_d, le_d;
    logic sclk_rise, le_rise;

    sl_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (.clk(clk), .rst_n(rst_n), .din(ser_clk), .dout(sclk_s));
    sl_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (.clk(clk), .rst_n(rst_n), .din(ser_dat), .dout(dat_s));
    sl_sync #(.STAGES(SYNC_STAGES)) u_sync_le  (.clk(clk), .rst_n(rst_n), .din(ser_le),  .dout(le_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = le_s & ~le_d;

    load_state_t st, st_nx;
    logic shift_en, ld_ref, ld_cnt, reject;
    logic [FRAME_W-1:0] word;
    logic to_ref, ref_ok, cnt_ok;
    ref_group_t ref_f, ref_q;
    cnt_group_t cnt_f, cnt_q;

    sl_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(dat_s), .word(word)
    );

    sl_frame_check #(.MIN_DIV(MIN_DIV)) u_check (
        .word(word), .to_ref(to_ref), .ref_f(ref_f), .cnt_f(cnt_f),
        .ref_ok(ref_ok), .cnt_ok(cnt_ok)
    );

    sl_field_bank u_bank (
        .clk(clk), .rst_n(rst_n), .ld_ref(ld_ref), .ld_cnt(ld_cnt),
        .ref_in(ref_f), .cnt_in(cnt_f), .ref_q(ref_q), .cnt_q(cnt_q),
        .configured(configured)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SHIFT;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_SHIFT: if (le_rise) st_nx = ST_CHECK;
            ST_CHECK: st_nx = ST_HOLD;
            ST_HOLD:  if (!le_s)   st_nx = ST_SHIFT;
            default:  st_nx = ST_SHIFT;
        endcase
    end

    // state outputs
    always_comb begin
        shift_en = 1'b0;
        ld_ref   = 1'b0;
        ld_cnt   = 1'b0;
        reject   = 1'b0;
        unique case (st)
            ST_SHIFT: shift_en = sclk_rise & ~le_s;
            ST_CHECK: begin
                ld_ref = to_ref & ref_ok;
                ld_cnt = ~to_ref & cnt_ok;
                reject = to_ref ? ~ref_ok : ~cnt_ok;
            end
            ST_HOLD:  ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_err <= 1'b0;
            sw_en    <= 1'b0;
        end else begin
            sw_en <= le_s;
            if (reject)                load_err <= 1'b1;
            else if (ld_ref || ld_cnt) load_err <= 1'b0;
        end
    end

    assign ref_ratio = ref_q.ratio;
    assign pre_sel   = ref_q.pre;
    assign swallow_a = cnt_q.a;
    assign count_b   = cnt_q.b;

    // R4
    ref_change_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_ratio) |-> $past(st) == ST_CHECK);

    // R4
    cnt_change_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_b) |-> $past(st) == ST_CHECK);

    // R6
    reject_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && to_ref && !ref_ok) |=> ($stable(ref_ratio) && $stable(pre_sel)));

    // R7
    reject_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !to_ref && !cnt_ok) |=> ($stable(swallow_a) && $stable(count_b)));

    // R9
    hold_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> $stable(word));

    // R12
    err_rise_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> $past(st) == ST_CHECK);
endmodule

// File: tb/synth_serial_loader_bench.sv
module synth_serial_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // kind: 1 reference frame (f1 ratio, f2 select), 0 counter frame (f1 A, f2 B)
    localparam int V_KIND [NV] = '{0, 1, 0, 1, 1, 0, 0, 0, 1, 0};
    localparam int V_F1   [NV] = '{0, 100, 5, 2, 3, 10, 30, 40, 16383, 127};
    localparam int V_F2   [NV] = '{1, 1, 20, 0, 0, 2, 29, 40, 1, 2047};
    localparam int V_ERR  [NV] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic pre_sel;
    logic [6:0] swallow_a;
    logic [10:0] count_b;
    logic sw_en, load_err, configured;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int e_ref = 0, e_pre = 0, e_a = 0, e_b = 0, e_err = 0;
    bit ref_seen = 0, cnt_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_serial_loader u_synth_serial_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .pre_sel(pre_sel), .swallow_a(swallow_a), .count_b(count_b),
        .sw_en(sw_en), .load_err(load_err), .configured(configured)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wclk(3);
        ser_clk = 1'b1;
        wclk(3);
        ser_clk = 1'b0;
        wclk(3);
    endtask

    task automatic send_word(input logic [18:0] w);
        for (int i = 18; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe(input string tag);
        ser_le = 1'b1;
        wclk(6);
        @(negedge clk);
        chk({tag, " R8 sw_en high"}, sw_en, 1);
        ser_le = 1'b0;
        wclk(6);
        @(negedge clk);
        chk({tag, " R8 sw_en low"}, sw_en, 0);
    endtask

    function automatic logic [18:0] mk_word(input int kind, input int f1, input int f2);
        logic [18:0] w;
        if (kind == 1) w = {3'b000, 1'(f2), 14'(f1), 1'b1};
        else           w = {11'(f2), 7'(f1), 1'b0};
        return w;
    endfunction

    task automatic check_all(input string tag);
        @(negedge clk);
        chk({tag, " R2 ref_ratio"}, ref_ratio, e_ref);
        chk({tag, " R5 pre_sel"}, pre_sel, e_pre);
        chk({tag, " R3 swallow_a"}, swallow_a, e_a);
        chk({tag, " R3 count_b"}, count_b, e_b);
        chk({tag, " R6 R7 R12 load_err"}, load_err, e_err);
        chk({tag, " R11 configured"}, configured, int'(ref_seen && cnt_seen));
    endtask

    initial begin
        wclk(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wclk(3);
        @(negedge clk);
        // R10 outputs during and after reset
        rst_n = 1'b1;
        wclk(2);
        check_all("R10 reset");
        chk("R10 sw_en", sw_en, 0);

        for (int v = 0; v < NV; v++) begin
            send_word(mk_word(V_KIND[v], V_F1[v], V_F2[v]));
            strobe($sformatf("vec%0d", v));
            e_err = V_ERR[v];
            if (V_ERR[v] == 0) begin
                if (V_KIND[v] == 1) begin e_ref = V_F1[v]; e_pre = V_F2[v]; ref_seen = 1; end
                else                begin e_a = V_F1[v];   e_b = V_F2[v];   cnt_seen = 1; end
            end
            check_all($sformatf("vec%0d", v));
        end

        // R4: full frame shifted with strobe low changes nothing until strobe
        send_word(mk_word(1, 500, 0));
        wclk(6);
        check_all("R4 before strobe");
        strobe("R4");
        e_ref = 500; e_pre = 0;
        check_all("R4 after strobe");

        // R9: clock edges while strobe high are ignored; restrobe reloads same frame
        send_word(mk_word(0, 6, 9));
        strobe("R9 load");
        e_a = 6; e_b = 9; e_err = 0;
        check_all("R9 load");
        ser_le = 1'b1;
        wclk(6);
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        ser_dat = 1'b0;
        ser_le = 1'b0;
        wclk(6);
        strobe("R9 restrobe");
        check_all("R9 restrobe");

        // R10: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        wclk(2);
        @(negedge clk);
        rst_n = 1'b1;
        e_ref = 0; e_pre = 0; e_a = 0; e_b = 0; e_err = 0; ref_seen = 0; cnt_seen = 0;
        check_all("R10 rerun reset");

        // R11: only the reference group written keeps configured low
        send_word(mk_word(1, 77, 1));
        strobe("R11 ref only");
        e_ref = 77; e_pre = 1; ref_seen = 1;
        check_all("R11 ref only");
        // R1: first bit sent lands in bit 18 (B msb)
        send_word(mk_word(0, 1, 1024));
        strobe("R1 msb");
        e_a = 1; e_b = 1024; cnt_seen = 1;
        check_all("R1 msb");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule